// File: doc/BRIEF.md
# Synchronous Burst SRAM Model

This block is a clocked, cycle-level model of a flow-through synchronous burst SRAM. Each word has two 9-bit lanes. Lane 0 is bits [8:0], with data byte [7:0] and parity bit 8. Lane 1 is bits [17:9], with data byte [16:9] and parity bit 17.

On the rising clock edge the block captures the address, the write data, three chip enables, two address strobes, the burst advance input and the write controls. Either of the two strobes can open a burst. Within a burst, a 2-bit counter produces four word addresses in interleaved or linear order. The upper address bits do not change during a burst.

Read data comes straight from the array at the current address, with no output register, in the cycle that follows the edge. An asynchronous output enable gates it. When the output is not driven it reads as zero, and a separate flag reports whether it is driven. While the sleep input is high, the block ignores all new accesses and writes and turns the output off. The stored contents are kept.

Top module: `burst_sram`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block becomes deselected, its burst counter clears and its write flag clears. `rdata_en` is then 0 and `rdata` is 0.
- R2: A start from the processor strobe (`strobe_proc_n`=0 and `cs_n`=0) loads `addr` and clears the counter. The block is selected only if `cs_hi`=1 and `cs2_n`=0. Write controls are ignored in that cycle.
- R3: A processor strobe with `cs_n`=1 has no effect. The controller strobe, the advance input or the hold rule then decides the edge.
- R4: A start from the controller strobe (`strobe_ctrl_n`=0, no processor start) loads `addr`, clears the counter and selects only if `cs_n`=0, `cs_hi`=1 and `cs2_n`=0. A write in that same cycle goes to the loaded address. No write occurs while the block is deselected.
- R5: With no start and `adv_n`=0, the 2-bit counter increments. The upper address bits are unchanged. After four steps the counter is back at the start offset.
- R6: With `order_lin`=0 the low two address bits are start XOR count. With `order_lin`=1 they are (start + count) mod 4.
- R7: `lane_we_n[0]`=0 writes bits [8:0] and `lane_we_n[1]`=0 writes bits [17:9]. A lane whose enable is 1 keeps its old contents.
- R8: `all_we_n`=0 writes both lanes, whatever the value of `lane_we_n`.
- R9: `rdata` shows the array word at the current burst address in the cycle right after the edge that set that address, with no extra register stage.
- R10: `rdata_en` is 1 only when the block is selected, `oe_n`=0, `sleep`=0 and the last edge performed no write. `oe_n` acts without waiting for a clock edge. When `rdata_en` is 0, `rdata` is 0.
- R11: While `sleep`=1, strobes, advance and writes are ignored. The address state and the memory contents are kept, and the output is off.
- R12: With neither strobe starting and `adv_n`=1, the address is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | AW | Word address captured on a start |
| cs_n | input | 1 | Primary chip enable, active low |
| cs_hi | input | 1 | Expansion chip enable, active high |
| cs2_n | input | 1 | Expansion chip enable, active low |
| strobe_proc_n | input | 1 | Processor address strobe, active low |
| strobe_ctrl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_lin | input | 1 | Burst order: 0 interleaved, 1 linear |
| all_we_n | input | 1 | Global write, active low |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| wdata | input | DW | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| rdata | output | DW | Read data, zero when not driven |
| rdata_en | output | 1 | High while read data is driven |

## Verification
The case that is hardest to reach from the ports is a continuation write whose lane mask differs from the one used at the burst start. The word it overwrites must already hold a known, non-uniform value, so that a lane which is not written can be seen to survive. The bench first fills the whole array through controller-strobe global writes. It then runs bursts in both orders that change the lane mask at every beat. Every word is read back by a later burst, and on every clock the output is compared with a behavioural reference memory. Cycles with sleep, a deselected controller start, and a processor strobe without the primary enable are placed in the middle of bursts, so that each one can disturb live state.

// File: rtl/sbs_pkg.sv
// Shared constants and the burst-offset helper for the burst SRAM model.
package sbs_pkg;
    // Width of one lane: 8 data bits plus 1 parity bit.
    localparam int LANE_W = 9;

    // Low two address bits for a burst beat, in either order.
    function automatic logic [1:0] burst_off(input logic [1:0] start,
                                             input logic [1:0] cnt,
                                             input logic       lin);
        burst_off = lin ? (start + cnt) : (start ^ cnt);
    endfunction
endpackage

// File: rtl/sbs_addr_ctrl.sv
// Address front end: decodes the two strobes, chip enables and advance
// input into the registered burst base, the 2-bit counter and the select
// flag. It also exposes the next-state values, so that a write can target
// the address the edge is loading.
// Assumes: AW >= 2; the state freezes while sleep is high.
module sbs_addr_ctrl #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sleep,
    input  logic [AW-1:0] addr,
    input  logic          cs_n,
    input  logic          cs_hi,
    input  logic          cs2_n,
    input  logic          strobe_proc_n,
    input  logic          strobe_ctrl_n,
    input  logic          adv_n,
    output logic          proc_start,
    output logic [AW-1:0] base_q,
    output logic [1:0]    cnt_q,
    output logic          sel_q,
    output logic [AW-1:0] nxt_base,
    output logic [1:0]    nxt_cnt,
    output logic          nxt_sel
);
    logic ctrl_start;
    logic exp_ok;

    // Expansion enables both asserted.
    assign exp_ok     = cs_hi && !cs2_n;
    // The processor strobe counts only with the primary enable asserted.
    assign proc_start = !sleep && !strobe_proc_n && !cs_n;
    // The controller strobe counts when no processor start wins this edge.
    assign ctrl_start = !sleep && !proc_start && !strobe_ctrl_n;

    // Next-state choice: start, advance or hold.
    always_comb begin
        nxt_base = base_q;
        nxt_cnt  = cnt_q;
        nxt_sel  = sel_q;
        if (proc_start) begin
            nxt_base = addr;
            nxt_cnt  = 2'd0;
            nxt_sel  = exp_ok;
        end else if (ctrl_start) begin
            nxt_base = addr;
            nxt_cnt  = 2'd0;
            nxt_sel  = !cs_n && exp_ok;
        end else if (!sleep && !adv_n) begin
            nxt_cnt  = cnt_q + 2'd1;
        end
    end

    // Burst state registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= 2'd0;
            sel_q  <= 1'b0;
        end else begin
            base_q <= nxt_base;
            cnt_q  <= nxt_cnt;
            sel_q  <= nxt_sel;
        end
    end
endmodule

// File: rtl/sbs_write_dec.sv
// Write decode: turns the global write and the per-lane enables into
// per-lane write strobes, gated by an allow condition from the top.
// Assumes: all enable inputs are active low.
module sbs_write_dec #(
    parameter int LANES = 2
) (
    input  logic             allow,
    input  logic             all_we_n,
    input  logic [LANES-1:0] lane_we_n,
    output logic [LANES-1:0] lane_wr,
    output logic             any_wr
);
    // One strobe per lane; the global write overrides the lane enable.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_wr[g] = allow && (!all_we_n || !lane_we_n[g]);
    end

    // Any lane written in this cycle.
    assign any_wr = |lane_wr;
endmodule

// File: rtl/sbs_array.sv
// Storage array, split into independent lane memories so that each lane
// can be written alone. Writes are synchronous; reads are combinational,
// which gives the flow-through output.
// Assumes: DEPTH is a power of two; contents are not reset.
module sbs_array #(
    parameter int DEPTH = 256,
    parameter int LANES = 2,
    parameter int LW    = 9,
    localparam int AW   = $clog2(DEPTH),
    localparam int DW   = LANES * LW
) (
    input  logic             clk,
    input  logic [AW-1:0]    wr_addr,
    input  logic [LANES-1:0] lane_wr,
    input  logic [DW-1:0]    wdata,
    input  logic [AW-1:0]    rd_addr,
    output logic [DW-1:0]    rdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LW-1:0] mem [DEPTH];

        // Lane write on the rising edge.
        always_ff @(posedge clk) begin
            if (lane_wr[g]) mem[wr_addr] <= wdata[g*LW +: LW];
        end

        // Lane read with no register stage.
        assign rdata[g*LW +: LW] = mem[rd_addr];
    end
endmodule

// File: rtl/burst_sram.sv
// Top of the synchronous burst SRAM model. It joins the address front end,
// the write decoder and the lane array. It tracks whether the last edge
// wrote, and gates the flow-through read data with the output enable,
// the select state and sleep.
// Assumes: DEPTH is a power of two of at least 4; inputs are synchronous
// except oe_n and the combinational use of sleep and order_lin.
module burst_sram
    import sbs_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int LANES = 2,
    localparam int AW   = $clog2(DEPTH),
    localparam int DW   = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic             cs_n,
    input  logic             cs_hi,
    input  logic             cs2_n,
    input  logic             strobe_proc_n,
    input  logic             strobe_ctrl_n,
    input  logic             adv_n,
    input  logic             order_lin,
    input  logic             all_we_n,
    input  logic [LANES-1:0] lane_we_n,
    input  logic [DW-1:0]    wdata,
    input  logic             oe_n,
    input  logic             sleep,
    output logic [DW-1:0]    rdata,
    output logic             rdata_en
);
    logic             proc_start;
    logic [AW-1:0]    base_q;
    logic [1:0]       cnt_q;
    logic             sel_q;
    logic [AW-1:0]    nxt_base;
    logic [1:0]       nxt_cnt;
    logic             nxt_sel;
    logic [LANES-1:0] lane_wr;
    logic             any_wr;
    logic             wr_allow;
    logic             wr_q;
    logic [AW-1:0]    wr_addr;
    logic [AW-1:0]    cur_addr;
    logic [DW-1:0]    arr_q;

    sbs_addr_ctrl #(.AW(AW)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .sleep         (sleep),
        .addr          (addr),
        .cs_n          (cs_n),
        .cs_hi         (cs_hi),
        .cs2_n         (cs2_n),
        .strobe_proc_n (strobe_proc_n),
        .strobe_ctrl_n (strobe_ctrl_n),
        .adv_n         (adv_n),
        .proc_start    (proc_start),
        .base_q        (base_q),
        .cnt_q         (cnt_q),
        .sel_q         (sel_q),
        .nxt_base      (nxt_base),
        .nxt_cnt       (nxt_cnt),
        .nxt_sel       (nxt_sel)
    );

    // A write needs reset released, no sleep, no processor start and a selected target.
    assign wr_allow = rst_n && !sleep && !proc_start && nxt_sel;

    sbs_write_dec #(.LANES(LANES)) u_wdec (
        .allow     (wr_allow),
        .all_we_n  (all_we_n),
        .lane_we_n (lane_we_n),
        .lane_wr   (lane_wr),
        .any_wr    (any_wr)
    );

    // Write address: the burst address this edge is loading.
    assign wr_addr  = {nxt_base[AW-1:2], burst_off(nxt_base[1:0], nxt_cnt, order_lin)};
    // Read address: the registered burst address.
    assign cur_addr = {base_q[AW-1:2], burst_off(base_q[1:0], cnt_q, order_lin)};

    sbs_array #(.DEPTH(DEPTH), .LANES(LANES), .LW(LANE_W)) u_arr (
        .clk     (clk),
        .wr_addr (wr_addr),
        .lane_wr (lane_wr),
        .wdata   (wdata),
        .rd_addr (cur_addr),
        .rdata   (arr_q)
    );

    // Remember whether the last active edge wrote; hold it through sleep.
    always_ff @(posedge clk) begin
        if (!rst_n)      wr_q <= 1'b0;
        else if (!sleep) wr_q <= any_wr;
    end

    // Output gating: selected, enabled, awake and not a write cycle.
    assign rdata_en = sel_q && !oe_n && !sleep && !wr_q;
    assign rdata    = rdata_en ? arr_q : '0;
endmodule

// File: rtl/burst_sram_chk.sv
// Property checker for burst_sram, attached through bind. It watches the
// ports and the registered burst state.
module burst_sram_chk #(
    parameter int AW = 8,
    parameter int DW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sleep,
    input logic          oe_n,
    input logic          cs_n,
    input logic          strobe_proc_n,
    input logic          strobe_ctrl_n,
    input logic          adv_n,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] rdata,
    input logic          rdata_en,
    input logic [AW-1:0] base_q,
    input logic [1:0]    cnt_q
);
    logic no_start;
    assign no_start = (strobe_proc_n || cs_n) && strobe_ctrl_n;

    p_undriven_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_en |-> rdata == '0);

    p_drive_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_en |-> (!oe_n && !sleep));

    p_sleep_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> ($stable(base_q) && $stable(cnt_q)));

    p_adv_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && no_start && !adv_n) |=>
            (cnt_q == $past(cnt_q) + 2'd1 && $stable(base_q)));

    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && no_start && adv_n) |=> ($stable(base_q) && $stable(cnt_q)));

    p_proc_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !strobe_proc_n && !cs_n) |=> (cnt_q == 2'd0 && base_q == $past(addr)));
endmodule

bind burst_sram burst_sram_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sleep         (sleep),
    .oe_n          (oe_n),
    .cs_n          (cs_n),
    .strobe_proc_n (strobe_proc_n),
    .strobe_ctrl_n (strobe_ctrl_n),
    .adv_n         (adv_n),
    .addr          (addr),
    .rdata         (rdata),
    .rdata_en      (rdata_en),
    .base_q        (base_q),
    .cnt_q         (cnt_q)
);

// File: tb/sim_burst_sram.sv
// Bench for burst_sram: a behavioural reference model is updated at each
// rising edge and compared with the outputs 1 ns later.
module sim_burst_sram;
    localparam int DEPTH = 256;
    localparam int AW    = 8;
    localparam int DW    = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          cs_n = 1'b0, cs_hi = 1'b1, cs2_n = 1'b0;
    logic          strobe_proc_n = 1'b1, strobe_ctrl_n = 1'b1, adv_n = 1'b1;
    logic          order_lin = 1'b0, all_we_n = 1'b1;
    logic [1:0]    lane_we_n = 2'b11;
    logic [DW-1:0] wdata = '0;
    logic          oe_n = 1'b0, sleep = 1'b0;
    logic [DW-1:0] rdata;
    logic          rdata_en;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    // Reference state.
    logic [DW-1:0] ref_mem [DEPTH];
    int m_base = 0, m_cnt = 0;
    bit m_sel = 0, m_wr = 0;

    always #5 clk = ~clk;

    burst_sram u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cs_n(cs_n), .cs_hi(cs_hi),
        .cs2_n(cs2_n), .strobe_proc_n(strobe_proc_n), .strobe_ctrl_n(strobe_ctrl_n),
        .adv_n(adv_n), .order_lin(order_lin), .all_we_n(all_we_n),
        .lane_we_n(lane_we_n), .wdata(wdata), .oe_n(oe_n), .sleep(sleep),
        .rdata(rdata), .rdata_en(rdata_en)
    );

    function automatic int m_addr();
        int s, lo;
        s  = m_base & 3;
        lo = order_lin ? ((s + m_cnt) & 3) : (s ^ m_cnt);
        return (m_base & ~3) | lo;
    endfunction

    function automatic bit exp_en();
        return m_sel && !oe_n && !sleep && !m_wr;
    endfunction

    function automatic logic [DW-1:0] exp_data();
        return exp_en() ? ref_mem[m_addr()] : '0;
    endfunction

    // Apply the requirements to the inputs seen at this edge.
    task automatic model_edge();
        bit ps, cst, w;
        logic [1:0] ln;
        if (!rst_n) begin
            m_base = 0; m_cnt = 0; m_sel = 0; m_wr = 0;
        end else if (!sleep) begin
            ps  = !strobe_proc_n && !cs_n;
            cst = !ps && !strobe_ctrl_n;
            if (ps) begin
                m_base = int'(addr); m_cnt = 0; m_sel = cs_hi && !cs2_n;
            end else if (cst) begin
                m_base = int'(addr); m_cnt = 0; m_sel = !cs_n && cs_hi && !cs2_n;
            end else if (!adv_n) begin
                m_cnt = (m_cnt + 1) & 3;
            end
            ln = !all_we_n ? 2'b11 : ~lane_we_n;
            w  = !ps && m_sel && (ln != 2'b00);
            if (w) begin
                if (ln[0]) ref_mem[m_addr()][8:0]  = wdata[8:0];
                if (ln[1]) ref_mem[m_addr()][17:9] = wdata[17:9];
            end
            m_wr = w;
        end
    endtask

    task automatic check(input string tag);
        total++;
        if (rdata_en !== exp_en() || rdata !== exp_data()) begin
            fails++;
            $display("FAIL %s: en=%0b data=%h expected en=%0b data=%h",
                     tag, rdata_en, rdata, exp_en(), exp_data());
        end
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        #1;
        check(tag);
    endtask

    task automatic idle();
        strobe_proc_n = 1'b1; strobe_ctrl_n = 1'b1; adv_n = 1'b1;
        all_we_n = 1'b1; lane_we_n = 2'b11; cs_n = 1'b0; cs_hi = 1'b1; cs2_n = 1'b0;
    endtask

    // Burst read from a processor start; write controls held active (R2, ignored).
    task automatic read_burst(input int a, input bit lin);
        order_lin = lin;
        idle();
        addr = AW'(a); strobe_proc_n = 1'b0; lane_we_n = 2'b00; all_we_n = 1'b0;
        wdata = DW'($urandom);
        step("R2 R9");
        idle();
        for (int k = 0; k < 4; k++) begin
            adv_n = 1'b0;
            step(lin ? "R5 R6 linear" : "R5 R6 interleaved");
        end
        idle();
    endtask

    // Burst write from a controller start, lane mask changed every beat (R7, R8).
    task automatic write_burst(input int a, input bit lin);
        order_lin = lin;
        idle();
        addr = AW'(a); strobe_ctrl_n = 1'b0;
        lane_we_n = 2'($urandom); all_we_n = 1'($urandom);
        wdata = DW'($urandom);
        step("R4 R7 R8");
        idle();
        for (int k = 0; k < 3; k++) begin
            adv_n = 1'b0; lane_we_n = 2'($urandom); all_we_n = 1'($urandom);
            wdata = DW'($urandom);
            step("R7 R8");
        end
        idle();
    endtask

    initial begin
        void'($urandom(32'h5eed));
        // R1: reset state
        rst_n = 1'b0;
        step("R1"); step("R1");
        rst_n = 1'b1;
        step("R1");

        // Fill every word with global writes from controller starts (R4, R8).
        for (int i = 0; i < DEPTH; i++) begin
            idle();
            addr = AW'(i); strobe_ctrl_n = 1'b0; all_we_n = 1'b0; lane_we_n = 2'b11;
            wdata = DW'(i * 977 + 18'h2a5a5);
            step("R4 R8 fill");
        end
        idle();

        for (int r = 0; r < 16; r++) read_burst(int'($urandom % DEPTH), r[0]);
        for (int r = 0; r < 24; r++) begin
            int a;
            a = int'($urandom % DEPTH);
            write_burst(a, r[1]);
            read_burst(a, r[0]);
        end

        // R12: hold with no strobe and no advance.
        read_burst(8'h37, 1'b1);
        for (int k = 0; k < 3; k++) step("R12 hold");

        // R3: processor strobe without primary enable; advance decides.
        strobe_proc_n = 1'b0; cs_n = 1'b1; adv_n = 1'b0;
        step("R3");
        idle();
        step("R3 no drive");
        cs_n = 1'b0; strobe_proc_n = 1'b0; addr = 8'h91;
        step("R2 reselect");
        idle();

        // R4: deselected controller start; the write must not land.
        strobe_ctrl_n = 1'b0; cs_hi = 1'b0; all_we_n = 1'b0; addr = 8'h91; wdata = 18'h3ffff;
        step("R4 deselect hi");
        idle();
        strobe_ctrl_n = 1'b0; cs2_n = 1'b1; all_we_n = 1'b0; addr = 8'h92; wdata = 18'h3ffff;
        step("R4 deselect lo");
        idle();
        read_burst(8'h90, 1'b0);

        // R11: sleep in the middle of a burst while every input is busy.
        read_burst(8'h44, 1'b0);
        strobe_proc_n = 1'b0; addr = 8'h10; step("R2");
        idle(); adv_n = 1'b0; step("R5");
        sleep = 1'b1;
        strobe_ctrl_n = 1'b0; addr = 8'h20; all_we_n = 1'b0; wdata = 18'h15555;
        step("R11 sleep");
        strobe_ctrl_n = 1'b1; adv_n = 1'b0;
        step("R11 sleep");
        sleep = 1'b0; idle();
        step("R11 wake");
        read_burst(8'h20, 1'b0);

        // R10: output enable without a clock edge.
        read_burst(8'h5c, 1'b1);
        #1; oe_n = 1'b1; #1; check("R10 oe off");
        oe_n = 1'b0; #1; check("R10 oe on");
        idle();
        strobe_ctrl_n = 1'b0; addr = 8'h5c; lane_we_n = 2'b10; wdata = 18'h0a5a5;
        step("R10 R7 write cycle");
        idle();
        step("R9 R7 read after write");

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; fails++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule